// File: doc/BRIEF.md
# Sklansky Parallel-Prefix Adder

This block adds two 16-bit unsigned operands and a carry-in. It returns a 16-bit sum and a carry-out, with no clock inside. Each bit position first forms its own generate and propagate terms. A divide-and-conquer prefix tree then builds, for every position, the generate term of the span reaching from that position down through the carry-in. The tree has log2(width) levels. At each level the span doubles, and one node at a block boundary fans out to half of the positions above it. The sum bits come from the per-bit propagate terms and these span carries.

The carry-in is folded into bit 0 before the tree starts. It acts as one more generating position below bit 0, so every span computed by the tree already includes it, and the tree needs no extra level. Cells whose low input already reaches the bottom of the word drop their propagate output, because nothing above ever needs it.

The block is purely combinational and keeps no state. Results follow the operands within the same clock period. Back-pressure therefore never arises inside it: the stage that registers the operands or the result owns any valid/ready handshake. The operand width is a parameter with a default of 16.

Top module: `sk_adder`

## Requirements
- R1: For every input, the 17-bit value {cout_o, sum_o} equals the unsigned sum a_i + b_i + cin_i.
- R2: A position where exactly one operand bit is 1 propagates an incoming carry and creates none. With b_i equal to the bitwise inverse of a_i and cin_i = 0, the result is sum_o = 16'hFFFF and cout_o = 0.
- R3: cin_i = 1 adds exactly one to the result. With an all-propagate word (b_i = ~a_i), the carry-in ripples out: sum_o = 0 and cout_o = 1.
- R4: Sum bit 0 equals a_i[0] XOR b_i[0] XOR cin_i, whatever the upper bits are.
- R5: Sum bit i (i >= 1) equals a_i[i] XOR b_i[i] XOR the carry out of positions i-1..0 plus carry-in. In particular, a_i = b_i = 1<<k gives sum_o = 1<<(k+1) for every k below 15.
- R6: cout_o is the carry out of the whole word. Both 16'h8000 + 16'h8000 and 16'hFFFF + 16'h0001 give sum_o = 0 and cout_o = 1.
- R7: 6 + 3 with cin_i = 0 gives 9, and 6 + 3 with cin_i = 1 gives 10.
- R8: Outputs depend only on the present inputs. A new operand pair shows its result 1 ns after being applied, with no clock edge in between.
- R9: A carry generated at bit 0 crosses all 15 upper propagate positions. 16'h0001 + 16'hFFFF gives sum_o = 0 and cout_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand, unsigned |
| b_i | input | 16 | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Low 16 bits of a_i + b_i + cin_i |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
A wrong span generate for position i shows up at the ports in the same evaluation. It flips sum bit i+1, and for i = 15 it flips cout_o. This only happens when the operands make that carry matter: a lower generate must meet an unbroken run of propagates. The directed cases therefore walk a single generate across every bit position and run carries through long propagate chains, so that each span boundary of the tree changes the output it feeds. The random vectors then compare every result against a plain addition.

// File: rtl/sk_pkg.sv
`timescale 1ns/1ps
package sk_pkg;

  // generate/propagate pair of a span of bit positions
  typedef struct packed {
    logic g;
    logic p;
  } sk_gp_t;

  // full combine: both span terms for a span not yet reaching the bottom
  function automatic sk_gp_t sk_black(input sk_gp_t hi, input sk_gp_t lo);
    sk_gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // reduced combine: low span already ends at the bottom, only the generate is kept
  function automatic logic sk_grey(input sk_gp_t hi, input logic lo_g);
    return hi.g | (hi.p & lo_g);
  endfunction

endpackage

// File: rtl/sk_pregen.sv
`timescale 1ns/1ps
module sk_pregen #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign prop_o[i] = a_i[i] ^ b_i[i];
    if (i == 0) begin : g_low
      // carry-in behaves as a generating position below bit 0
      assign gen_o[i] = (a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & cin_i);
    end else begin : g_up
      assign gen_o[i] = a_i[i] & b_i[i];
    end
  end

  // a plain position can never both generate and propagate
  always_comb begin
    for (int i = 1; i < W; i++) begin
      assert_gen_prop_exclusive_R2: assert (!(gen_o[i] && prop_o[i]))
        else $error("position %0d both generates and propagates", i);
    end
  end

endmodule

// File: rtl/sk_prefix_tree.sv
`timescale 1ns/1ps
module sk_prefix_tree
  import sk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] gen_i,
  input  logic [W-1:0] prop_i,
  output logic [W-1:0] span_g_o
);

  localparam int LEVELS = (W > 1) ? $clog2(W) : 1;

  always_comb begin
    logic [W-1:0] gc, pc, gn, pn;
    int lo;
    gc = gen_i;
    pc = prop_i;
    for (int k = 0; k < LEVELS; k++) begin
      gn = gc;
      pn = pc;
      for (int i = 0; i < W; i++) begin
        if (((i >> k) & 1) == 1) begin
          // highest position below the 2^k-aligned block holding i
          lo = ((i >> k) << k) - 1;
          if (i < (2 << k)) begin
            gn[i] = sk_grey('{g: gc[i], p: pc[i]}, gc[lo]);
            pn[i] = 1'b0;
          end else begin
            {gn[i], pn[i]} = sk_black('{g: gc[i], p: pc[i]}, '{g: gc[lo], p: pc[lo]});
          end
        end
      end
      gc = gn;
      pc = pn;
    end
    span_g_o = gc;
  end

  always_comb begin
    assert_bottom_passthrough_R4: assert (span_g_o[0] == gen_i[0])
      else $error("bottom span differs from its own generate");
    for (int i = 0; i < W; i++) begin
      assert_span_keeps_own_gen_R5: assert (!(gen_i[i] && !span_g_o[i]))
        else $error("span %0d lost its own generate", i);
    end
  end

endmodule

// File: rtl/sk_sumgen.sv
`timescale 1ns/1ps
module sk_sumgen #(
  parameter int W = 16
) (
  input  logic [W-1:0] prop_i,
  input  logic [W-1:0] span_g_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  for (genvar i = 0; i < W; i++) begin : g_sum
    if (i == 0) begin : g_low
      assign sum_o[i] = prop_i[i] ^ cin_i;
    end else begin : g_up
      assign sum_o[i] = prop_i[i] ^ span_g_i[i-1];
    end
  end

  assign cout_o = span_g_i[W-1];

endmodule

// File: rtl/sk_adder.sv
`timescale 1ns/1ps
module sk_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W-1:0] gen_w, prop_w, span_g_w;

  sk_pregen #(.W(W)) u_pre (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .gen_o  (gen_w),
    .prop_o (prop_w)
  );

  sk_prefix_tree #(.W(W)) u_tree (
    .gen_i    (gen_w),
    .prop_i   (prop_w),
    .span_g_o (span_g_w)
  );

  sk_sumgen #(.W(W)) u_sum (
    .prop_i   (prop_w),
    .span_g_i (span_g_w),
    .cin_i    (cin_i),
    .sum_o    (sum_o),
    .cout_o   (cout_o)
  );

  always_comb begin
    assert_total_matches_R1: assert ({cout_o, sum_o} ==
        ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
      else $error("result differs from operand total");
    assert_low_sum_bit_R4: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i))
      else $error("sum bit 0 wrong");
  end

endmodule

// File: tb/sk_adder_test.sv
`timescale 1ns/1ps
module sk_adder_test;

  localparam real CLK_NS = 5.0;

  logic clk = 1'b0;
  always #(CLK_NS / 2.0) clk = ~clk;

  logic [15:0] a_s = '0, b_s = '0;
  logic        cin_s = 1'b0;
  logic [15:0] sum_w;
  logic        cout_w;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  sk_adder #(.W(16)) uut (
    .a_i    (a_s),
    .b_i    (b_s),
    .cin_i  (cin_s),
    .sum_o  (sum_w),
    .cout_o (cout_w)
  );

  // {a, b, cin, expected {cout, sum}}
  localparam int NV = 10;
  localparam logic [49:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 1'b0, 17'h00000},
    {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
    {16'h1234, 16'h4321, 1'b0, 17'h05555},
    {16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE},
    {16'h00FF, 16'h0001, 1'b0, 17'h00100},
    {16'h7FFF, 16'h0000, 1'b1, 17'h08000},
    {16'hF0F0, 16'h0F10, 1'b0, 17'h10000},
    {16'h8001, 16'h7FFF, 1'b1, 17'h10001},
    {16'h0F0F, 16'h0F0F, 1'b1, 17'h01E1F},
    {16'hC000, 16'h4000, 1'b0, 17'h10000}
  };

  task automatic check(input string tag, input logic [15:0] a, input logic [15:0] b,
                       input logic c, input logic [16:0] expv);
    logic [16:0] got;
    a_s = a; b_s = b; cin_s = c;
    @(negedge clk);
    got = {cout_w, sum_w};
    n_cmp++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h cin=%b got %h expected %h", tag, a, b, c, got, expv);
    end
  endtask

  initial begin
    @(negedge clk);
    // idle state with all-zero inputs
    n_cmp++;
    if ({cout_w, sum_w} !== 17'h0) begin
      n_bad++;
      $display("FAIL R1 idle: got %h expected 00000", {cout_w, sum_w});
    end

    // R1 table walk
    for (int v = 0; v < NV; v++)
      check("R1", VEC[v][49:34], VEC[v][33:18], VEC[v][17], VEC[v][16:0]);

    // R2 all-propagate words
    check("R2", 16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF);
    check("R2", 16'hFFFF, 16'h0000, 1'b0, 17'h0FFFF);
    check("R2", 16'h3C69, 16'hC396, 1'b0, 17'h0FFFF);

    // R3 carry-in
    check("R3", 16'hAAAA, 16'h5555, 1'b1, 17'h10000);
    check("R3", 16'h0000, 16'h0000, 1'b1, 17'h00001);
    check("R3", 16'h1000, 16'h0234, 1'b1, 17'h01235);

    // R4 bit 0
    check("R4", 16'h0001, 16'h0000, 1'b0, 17'h00001);
    check("R4", 16'h0001, 16'h0001, 1'b1, 17'h00003);
    check("R4", 16'hFFFE, 16'h0000, 1'b1, 17'h0FFFF);

    // R5 single generate walked across every position
    for (int k = 0; k < 15; k++)
      check("R5", 16'(1 << k), 16'(1 << k), 1'b0, 17'(1 << (k + 1)));

    // R6 carry-out
    check("R6", 16'h8000, 16'h8000, 1'b0, 17'h10000);
    check("R6", 16'hFFFF, 16'h0001, 1'b0, 17'h10000);
    check("R6", 16'h7FFF, 16'h8000, 1'b0, 17'h0FFFF);

    // R7 worked example
    check("R7", 16'h0006, 16'h0003, 1'b0, 17'h00009);
    check("R7", 16'h0006, 16'h0003, 1'b1, 17'h0000A);

    // R9 longest chain
    check("R9", 16'h0001, 16'hFFFF, 1'b0, 17'h10000);
    check("R9", 16'h0000, 16'hFFFF, 1'b1, 17'h10000);

    // R8 result follows inputs with no clock edge in between
    @(posedge clk);
    #0.5;
    a_s = 16'h0102; b_s = 16'h0304; cin_s = 1'b0;
    #1;
    n_cmp++;
    if ({cout_w, sum_w} !== 17'h00406) begin
      n_bad++;
      $display("FAIL R8: got %h expected 00406", {cout_w, sum_w});
    end
    a_s = 16'hFFF0; b_s = 16'h0010;
    #1;
    n_cmp++;
    if ({cout_w, sum_w} !== 17'h10000) begin
      n_bad++;
      $display("FAIL R8: got %h expected 10000", {cout_w, sum_w});
    end

    // R1 random sweep against plain addition
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] ra, rb;
      logic rc;
      ra = 16'($urandom);
      rb = 16'($urandom);
      rc = 1'($urandom);
      check("R1", ra, rb, rc, {1'b0, ra} + {1'b0, rb} + {16'h0, rc});
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000.0);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule